// File: doc/BRIEF.md
# Parallel Flash Byte-Program Sequencer

This block sits on the host side of an asynchronous 8-bit NOR flash and turns a single program request into the flash's automated byte-program flow. A requester presents a 20-bit byte address, a data byte and three mode bits: whether this byte ends a run, whether the full status check is deferred to the end of the run, and whether completion is taken from the ready/busy pin or from status-register polling. The sequencer then owns the flash bus until the request is finished.

Every bus access goes through one shared cycle engine. It drives address and data, lowers CE#, pulses WE# or OE# for a parameterised number of clocks and holds the bus afterwards. The controller steps through the states IDLE, SETUP (write the setup code), DATA (write the byte), WHRL (minimum wait after the data write), then WAIT_PIN (watch the synchronised ready pin) or POLL (repeat status reads until bit 7 is set). From WAIT_PIN it moves to STAT (one status read for the full check). After the check come CLEAR (clear-status command) when any error was seen, RESET (read-array command) when the byte ends a run or an error was seen, and DONE (one-cycle result pulse) before it returns to IDLE.

Transitions: IDLE to SETUP on a request. SETUP to DATA, and DATA to WHRL, when each bus cycle ends. WHRL to WAIT_PIN or POLL when the wait counter reaches zero. WAIT_PIN to STAT when ready and a full check is due, to DONE when ready and the check is deferred, and to CLEAR on timeout. POLL repeats itself while busy. On ready, POLL behaves like STAT when a full check is due and goes to DONE otherwise. On timeout it goes to CLEAR. STAT and POLL go to CLEAR on an error, to RESET at the end of a run, and otherwise to DONE. CLEAR goes to RESET, RESET goes to DONE, and DONE goes to IDLE.

Top module: `flash_byte_prog`

## Requirements
- R1: While reset is held and on leaving it, CE#, OE# and WE# are high, the data bus is not driven, and busy and done are low.
- R2: An accepted request first writes the setup code 40H to the request address, then writes the request data byte to the same address.
- R3: Each WE# low pulse lasts exactly T_WP clocks, with CE# low and the data bus driven for its whole length.
- R4: In pin mode (ready pin high = ready, low = busy), no status read is started while the flash is still busy, and the first pin sample is taken no earlier than T_WHRL clocks after the data write ends.
- R5: In poll mode each status read is a separate OE# low window with CE# and OE# returning high between reads, and polling stops on the first read that shows status bit 7 = 1. OE# and WE# are never low together, and the data bus is not driven while OE# is low.
- R6: When the full check runs, status bit 3 = 1 is reported on err_vpp and status bit 4 = 1 on err_prog, together with done.
- R7: After any detected error, a clear-status write of 50H is issued before the read-array write and before done.
- R8: A read-array write of FFH is issued after the last byte of a run or after an error, and no command beyond the two program writes is issued for a clean byte that does not end a run.
- R9: With the deferred check selected, status bits 3 and 4 are not reported for a byte that does not end a run. They are decoded at the byte that ends it.
- R10: If ready is not seen within TMO_CYCLES clocks of waiting, done carries err_timeout, and the clear-status (50H) and read-array (FFH) writes follow the two program writes.
- R11: done is a one-cycle pulse after which busy is low. Requests presented while busy are ignored and cause no bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Program request, taken only while idle |
| req_addr | input | 20 | Byte address to program |
| req_data | input | 8 | Byte to program |
| req_last | input | 1 | This byte ends a run |
| req_defer | input | 1 | 1 = deferred status check, 0 = check each byte |
| req_by_pin | input | 1 | 1 = completion from ready pin, 0 = status polling |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_vpp | output | 1 | Programming-voltage error, valid with done |
| err_prog | output | 1 | Byte-program error, valid with done |
| err_timeout | output | 1 | Ready not seen in time, valid with done |
| flash_addr | output | 20 | Flash address bus |
| flash_dq_o | output | 8 | Flash data out |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Flash data in |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_rdy | input | 1 | Ready/busy pin, high = ready |

## Verification
WE# stays low for exactly T_WP clocks, so the bench counts low samples at falling edges and compares on the rising edge. A status read cannot start before T_WHRL clocks plus two synchroniser clocks after the data write. The bench therefore counts OE# falls while its flash model is still busy: there must be none in pin mode, and at least one, with repeated windows, in poll mode. done rises one clock after the engine finishes the last bus cycle and lasts one clock. The bench polls it at every falling edge under a bound and confirms it low one falling edge later. The timeout is due no earlier than TMO_CYCLES clocks after waiting begins, and the bench checks this against the elapsed clock count.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_WHRL,
        ST_WAIT_PIN,
        ST_STAT,
        ST_POLL,
        ST_CLEAR,
        ST_RESET,
        ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        BC_IDLE,
        BC_SETUP,
        BC_STROBE,
        BC_HOLD,
        BC_DONE
    } bus_phase_t;

    localparam logic [7:0] CMD_SETUP      = 8'h40;
    localparam logic [7:0] CMD_SETUP_ALT  = 8'h10;
    localparam logic [7:0] CMD_CLEAR      = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int SR_READY = 7;
    localparam int SR_PROG  = 4;
    localparam int SR_VPP   = 3;

endpackage

// File: rtl/fps_sync.sv
module fps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fps_bus_cycle.sv
module fps_bus_cycle
    import fps_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int T_SU  = 2,
    parameter int T_WP  = 4,
    parameter int T_HLD = 2,
    parameter int T_ACC = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dq_o,
    output logic          bus_dq_oe,
    input  logic [DW-1:0] bus_dq_i,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n
);
    localparam int T_A  = (T_SU > T_WP) ? T_SU : T_WP;
    localparam int T_B  = (T_HLD > T_ACC) ? T_HLD : T_ACC;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int CW   = $clog2(TMAX + 1);

    bus_phase_t    phase_q;
    logic [CW-1:0] cnt_q;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= BC_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (phase_q)
                BC_IDLE: begin
                    if (start) begin
                        phase_q <= BC_SETUP;
                        cnt_q   <= CW'(T_SU - 1);
                        rd_q    <= is_read;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                    end
                end
                BC_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= BC_STROBE;
                        cnt_q   <= rd_q ? CW'(T_ACC - 1) : CW'(T_WP - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BC_STROBE: begin
                    if (cnt_zero) begin
                        phase_q <= BC_HOLD;
                        cnt_q   <= CW'(T_HLD - 1);
                        if (rd_q) rdata_q <= bus_dq_i;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BC_HOLD: begin
                    if (cnt_zero) phase_q <= BC_DONE;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                BC_DONE: phase_q <= BC_IDLE;
                default: phase_q <= BC_IDLE;
            endcase
        end
    end

    always_comb begin
        logic active;
        active    = (phase_q == BC_SETUP) || (phase_q == BC_STROBE) || (phase_q == BC_HOLD);
        ce_n      = !active;
        oe_n      = !((phase_q == BC_STROBE) && rd_q);
        we_n      = !((phase_q == BC_STROBE) && !rd_q);
        bus_dq_oe = active && !rd_q;
        ack       = (phase_q == BC_DONE);
        bus_addr  = addr_q;
        bus_dq_o  = wdata_q;
        rdata     = rdata_q;
    end
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
    import fps_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 8,
    parameter int T_SU       = 2,
    parameter int T_WP       = 4,
    parameter int T_HLD      = 2,
    parameter int T_ACC      = 10,
    parameter int T_WHRL     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_CYCLES = 2000,
    parameter bit ALT_SETUP  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_last,
    input  logic          req_defer,
    input  logic          req_by_pin,
    output logic          busy,
    output logic          done,
    output logic          err_vpp,
    output logic          err_prog,
    output logic          err_timeout,
    output logic [AW-1:0] flash_addr,
    output logic [DW-1:0] flash_dq_o,
    output logic          flash_dq_oe,
    input  logic [DW-1:0] flash_dq_i,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n,
    input  logic          flash_rdy
);
    localparam logic [7:0] SETUP_BYTE = ALT_SETUP ? CMD_SETUP_ALT : CMD_SETUP;
    localparam int WW = $clog2(T_WHRL + 1);
    localparam int TW = $clog2(TMO_CYCLES + 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          last_q, defer_q, pin_q;
    logic          issued_q;
    logic [WW-1:0] whrl_q;
    logic [TW-1:0] tmo_q;
    logic          e_vpp_q, e_prog_q, e_tmo_q;

    logic          cyc_start, cyc_read, cyc_ack;
    logic [DW-1:0] cyc_byte, cyc_rdata;
    logic          rdy_s;
    logic          full_chk, tmo_hit, sr_ready, sr_err, bus_state;
    logic          unused_sr_bits;
    seq_state_t    after_status;

    fps_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (flash_rdy),
        .q    (rdy_s)
    );

    fps_bus_cycle #(
        .AW(AW), .DW(DW), .T_SU(T_SU), .T_WP(T_WP), .T_HLD(T_HLD), .T_ACC(T_ACC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .is_read  (cyc_read),
        .addr     (addr_q),
        .wdata    (cyc_byte),
        .ack      (cyc_ack),
        .rdata    (cyc_rdata),
        .bus_addr (flash_addr),
        .bus_dq_o (flash_dq_o),
        .bus_dq_oe(flash_dq_oe),
        .bus_dq_i (flash_dq_i),
        .ce_n     (flash_ce_n),
        .oe_n     (flash_oe_n),
        .we_n     (flash_we_n)
    );

    assign full_chk       = !defer_q || last_q;
    assign tmo_hit        = (tmo_q == TW'(TMO_CYCLES - 1));
    assign sr_ready       = cyc_rdata[SR_READY];
    assign sr_err         = cyc_rdata[SR_VPP] || cyc_rdata[SR_PROG];
    assign unused_sr_bits = ^{cyc_rdata[6:5], cyc_rdata[2:0]};
    assign after_status   = sr_err ? ST_CLEAR : (last_q ? ST_RESET : ST_DONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_SETUP;
            ST_SETUP:    if (cyc_ack) state_d = ST_DATA;
            ST_DATA:     if (cyc_ack) state_d = ST_WHRL;
            ST_WHRL:     if (whrl_q == '0) state_d = pin_q ? ST_WAIT_PIN : ST_POLL;
            ST_WAIT_PIN: begin
                if (rdy_s)        state_d = full_chk ? ST_STAT : ST_DONE;
                else if (tmo_hit) state_d = ST_CLEAR;
            end
            ST_STAT:     if (cyc_ack) state_d = after_status;
            ST_POLL: begin
                if (cyc_ack) begin
                    if (sr_ready)     state_d = full_chk ? after_status : ST_DONE;
                    else if (tmo_hit) state_d = ST_CLEAR;
                end
            end
            ST_CLEAR:    if (cyc_ack) state_d = ST_RESET;
            ST_RESET:    if (cyc_ack) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context, counters and error capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            data_q   <= '0;
            last_q   <= 1'b0;
            defer_q  <= 1'b0;
            pin_q    <= 1'b0;
            issued_q <= 1'b0;
            whrl_q   <= '0;
            tmo_q    <= '0;
            e_vpp_q  <= 1'b0;
            e_prog_q <= 1'b0;
            e_tmo_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q   <= req_addr;
                data_q   <= req_data;
                last_q   <= req_last;
                defer_q  <= req_defer;
                pin_q    <= req_by_pin;
                tmo_q    <= '0;
                e_vpp_q  <= 1'b0;
                e_prog_q <= 1'b0;
                e_tmo_q  <= 1'b0;
            end

            if (cyc_ack)        issued_q <= 1'b0;
            else if (cyc_start) issued_q <= 1'b1;

            if (state_q == ST_DATA && cyc_ack)         whrl_q <= WW'(T_WHRL - 1);
            else if (state_q == ST_WHRL && whrl_q != '0) whrl_q <= whrl_q - 1'b1;

            if ((state_q == ST_WAIT_PIN || state_q == ST_POLL) && !tmo_hit)
                tmo_q <= tmo_q + 1'b1;

            if ((state_q == ST_STAT && cyc_ack) ||
                (state_q == ST_POLL && cyc_ack && sr_ready && full_chk)) begin
                e_vpp_q  <= cyc_rdata[SR_VPP];
                e_prog_q <= cyc_rdata[SR_PROG];
            end

            if ((state_q == ST_WAIT_PIN && !rdy_s && tmo_hit) ||
                (state_q == ST_POLL && cyc_ack && !sr_ready && tmo_hit))
                e_tmo_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_state = 1'b0;
        cyc_read  = 1'b0;
        cyc_byte  = CMD_READ_ARRAY;
        unique case (state_q)
            ST_SETUP: begin bus_state = 1'b1; cyc_byte = SETUP_BYTE; end
            ST_DATA:  begin bus_state = 1'b1; cyc_byte = data_q; end
            ST_STAT,
            ST_POLL:  begin bus_state = 1'b1; cyc_read = 1'b1; end
            ST_CLEAR: begin bus_state = 1'b1; cyc_byte = CMD_CLEAR; end
            ST_RESET: begin bus_state = 1'b1; cyc_byte = CMD_READ_ARRAY; end
            default:  bus_state = 1'b0;
        endcase
        cyc_start   = bus_state && !issued_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        err_vpp     = done && e_vpp_q;
        err_prog    = done && e_prog_q;
        err_timeout = done && e_tmo_q;
    end
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int T_WP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic flash_ce_n,
    input logic flash_oe_n,
    input logic flash_we_n,
    input logic flash_dq_oe,
    input logic busy,
    input logic done,
    input logic err_vpp,
    input logic err_prog,
    input logic err_timeout
);
    localparam int CW = $clog2(T_WP + 2);
    logic [CW-1:0] we_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           we_lo_q <= '0;
        else if (flash_we_n)                  we_lo_q <= '0;
        else if (we_lo_q != {CW{1'b1}})       we_lo_q <= we_lo_q + 1'b1;
    end

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (we_lo_q == CW'(T_WP)));

    p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (!flash_ce_n && flash_dq_oe));

    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_oe_n && !flash_we_n));

    p_oe_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_dq_oe);

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vpp || err_prog || err_timeout) |-> done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe));
endmodule

bind flash_byte_prog fps_checker #(.T_WP(T_WP)) u_fps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_ce_n (flash_ce_n),
    .flash_oe_n (flash_oe_n),
    .flash_we_n (flash_we_n),
    .flash_dq_oe(flash_dq_oe),
    .busy       (busy),
    .done       (done),
    .err_vpp    (err_vpp),
    .err_prog   (err_prog),
    .err_timeout(err_timeout)
);

// File: tb/tb_flash_byte_prog.sv
module tb_flash_byte_prog;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 300;
    localparam int BUSY_LEN   = 40;
    localparam int T_WP       = 4;
    localparam int NVEC       = 9;

    // {by_pin, defer, last, inj[1:0] (bit1 -> SR bit4, bit0 -> SR bit3),
    //  exp_vpp, exp_prog, exp_clear, exp_reset}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b1_0_1_00_0_0_0_1,
        9'b0_0_1_00_0_0_0_1,
        9'b0_0_0_10_0_1_1_1,
        9'b1_0_0_01_1_0_1_1,
        9'b1_1_0_10_0_0_0_0,
        9'b0_1_0_00_0_0_0_0,
        9'b0_1_1_00_0_1_1_1,
        9'b1_0_0_00_0_0_0_0,
        9'b0_0_0_11_1_1_1_1
    };

    logic        clk, rst_n;
    logic        req_valid, req_last, req_defer, req_by_pin;
    logic [19:0] req_addr;
    logic [7:0]  req_data;
    logic        busy, done, err_vpp, err_prog, err_timeout;
    logic [19:0] flash_addr;
    logic [7:0]  flash_dq_o, flash_dq_i;
    logic        flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n, flash_rdy;

    int checks = 0;
    int errors = 0;

    flash_byte_prog #(.TMO_CYCLES(TMO), .T_WP(T_WP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_last(req_last), .req_defer(req_defer),
        .req_by_pin(req_by_pin), .busy(busy), .done(done), .err_vpp(err_vpp),
        .err_prog(err_prog), .err_timeout(err_timeout), .flash_addr(flash_addr),
        .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe), .flash_dq_i(flash_dq_i),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_rdy(flash_rdy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- flash model ----------------
    logic        m_busy, m_expect, we_prev, oe_prev;
    logic [1:0]  m_sticky;
    logic [1:0]  m_inj;
    logic        m_stuck;
    logic [7:0]  sr_lat;
    int          m_cnt, we_lo, we_bad, log_n, rd_n, rd_busy;
    logic [19:0] log_addr [256];
    logic [7:0]  log_data [256];

    assign flash_rdy  = !m_busy;
    assign flash_dq_i = sr_lat;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_expect = 1'b0; m_sticky = 2'b00; sr_lat = 8'h80;
            we_prev = 1'b1; oe_prev = 1'b1; m_cnt = 0; we_lo = 0; we_bad = 0;
            log_n = 0; rd_n = 0; rd_busy = 0;
        end else begin
            if (!flash_we_n) we_lo++;
            if (!we_prev && flash_we_n) begin
                if (we_lo != T_WP) we_bad++;
                we_lo = 0;
                log_addr[log_n[7:0]] = flash_addr;
                log_data[log_n[7:0]] = flash_dq_o;
                log_n++;
                if (m_expect) begin
                    m_expect = 1'b0; m_busy = 1'b1; m_cnt = BUSY_LEN;
                end else if (flash_dq_o == 8'h40 || flash_dq_o == 8'h10) begin
                    m_expect = 1'b1;
                end else if (flash_dq_o == 8'h50) begin
                    m_sticky = 2'b00;
                end
            end
            if (oe_prev && !flash_oe_n) begin
                sr_lat = {!m_busy, 2'b00, m_sticky, 3'b000};
                rd_n++;
                if (m_busy) rd_busy++;
            end
            if (m_busy && !m_stuck) begin
                if (m_cnt <= 1) begin
                    m_busy = 1'b0; m_sticky = m_sticky | m_inj;
                end else m_cnt--;
            end
            we_prev = flash_we_n;
            oe_prev = flash_oe_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic r_done, r_v, r_p, r_t;
    int   r_cyc;

    task automatic wait_done();
        r_done = 1'b0; r_v = 1'b0; r_p = 1'b0; r_t = 1'b0;
        while (!r_done && r_cyc < 5000) begin
            if (done) begin
                r_done = 1'b1; r_v = err_vpp; r_p = err_prog; r_t = err_timeout;
            end else begin
                @(negedge clk); r_cyc++;
            end
        end
        @(negedge clk);
        chk(!done && !busy, "R11 done single pulse then idle", {done, busy}, 0);
    endtask

    task automatic run_req(input logic [19:0] a, input logic [7:0] d,
                           input bit last, input bit defer, input bit pin);
        @(negedge clk);
        req_addr = a; req_data = d; req_last = last; req_defer = defer;
        req_by_pin = pin; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; r_cyc = 1;
        wait_done();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, rbase, bbase, nexp, clr, rst;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        req_last = 1'b0; req_defer = 1'b0; req_by_pin = 1'b0;
        m_inj = 2'b00; m_stuck = 1'b0;
        repeat (4) @(negedge clk);
        chk(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !busy && !done,
            "R1 reset outputs", {flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, busy, done}, 6'b111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flash_ce_n && !busy && !done, "R1 after reset", {flash_ce_n, busy, done}, 3'b100);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] a;
            logic [7:0]  d;
            a = 20'h01000 + 20'(i * 'h111);
            d = 8'h3C + 8'(i);
            m_inj = VEC[i][5:4];
            base = log_n; rbase = rd_n; bbase = rd_busy;
            clr = int'(VEC[i][1]); rst = int'(VEC[i][0]);
            run_req(a, d, VEC[i][6], VEC[i][7], VEC[i][8]);
            chk(r_done, "R11 done seen", r_done, 1);
            nexp = 2 + clr + rst;
            chk(log_n - base == nexp, "R8 write count", log_n - base, nexp);
            chk(log_data[base[7:0]] == 8'h40 && log_addr[base[7:0]] == a,
                "R2 setup write", log_data[base[7:0]], 8'h40);
            chk(log_data[8'(base + 1)] == d && log_addr[8'(base + 1)] == a,
                "R2 data write", log_data[8'(base + 1)], d);
            if (clr == 1)
                chk(log_data[8'(base + 2)] == 8'h50, "R7 clear before reset", log_data[8'(base + 2)], 8'h50);
            if (rst == 1)
                chk(log_data[8'(base + 2 + clr)] == 8'hFF, "R8 read-array write",
                    log_data[8'(base + 2 + clr)], 8'hFF);
            chk(r_v == VEC[i][3], "R6 err_vpp", r_v, VEC[i][3]);
            chk(r_p == VEC[i][2], "R6 R9 err_prog", r_p, VEC[i][2]);
            chk(!r_t, "R10 no timeout", r_t, 0);
            if (VEC[i][8])
                chk(rd_busy - bbase == 0, "R4 no read while busy", rd_busy - bbase, 0);
            else
                chk(rd_busy - bbase >= 1 && rd_n - rbase >= 2, "R5 repeated polls",
                    rd_n - rbase, 2);
        end

        // R10 timeout in poll mode
        m_inj = 2'b00; m_stuck = 1'b1; base = log_n;
        run_req(20'h0ABCD, 8'h5A, 1'b1, 1'b0, 1'b0);
        chk(r_t, "R10 timeout flagged (poll)", r_t, 1);
        chk(r_cyc >= TMO, "R10 timeout not early", r_cyc, TMO);
        chk(log_n - base == 4 && log_data[8'(base + 2)] == 8'h50 && log_data[8'(base + 3)] == 8'hFF,
            "R10 clear and reset after timeout", log_n - base, 4);
        m_stuck = 1'b0;
        repeat (BUSY_LEN + 5) @(negedge clk);

        // R10 timeout in pin mode
        m_stuck = 1'b1;
        run_req(20'h0BCDE, 8'hA5, 1'b0, 1'b0, 1'b1);
        chk(r_t && !r_v && !r_p, "R10 timeout flagged (pin)", {r_t, r_v, r_p}, 3'b100);
        m_stuck = 1'b0;
        repeat (BUSY_LEN + 5) @(negedge clk);

        // R11 request during busy is ignored
        base = log_n;
        @(negedge clk);
        req_addr = 20'h0C000; req_data = 8'h11; req_last = 1'b1; req_defer = 1'b0;
        req_by_pin = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_addr = 20'h0D000; req_data = 8'h22; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0; r_cyc = 9;
        wait_done();
        repeat (10) @(negedge clk);
        chk(log_n - base == 3, "R11 no extra writes", log_n - base, 3);
        chk(log_addr[8'(base + 1)] == 20'h0C000 && log_data[8'(base + 1)] == 8'h11,
            "R11 first request kept", log_data[8'(base + 1)], 8'h11);
        chk(!busy, "R11 idle after ignored request", busy, 0);

        chk(we_bad == 0, "R3 WE pulse width", we_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule